// File: doc/BRIEF.md
# Receive Character Buffer with Trigger Threshold

This block holds characters that a serial receiver has assembled until a host picks them up through a byte-wide register interface. Each stored entry keeps the data byte together with that character's parity, framing and break indications. The host sees a receiver-ready status whenever something is waiting, and a trigger-reached signal once occupancy reaches one of four selectable levels. The trigger signal is meant to drive a receive interrupt at a coarser rate than one per character.

A control write selects the mode and the threshold. In buffered mode, up to 16 characters queue in arrival order, and a character that arrives while the queue is full is dropped. In unbuffered mode, the block keeps only one character, and a new arrival replaces the unread one. Both losses set a sticky overrun status. Reading line status clears the overrun status and the error flags shown for the head character.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset, rx_ready, overrun, trig_hit and all three error outputs are 0, and the block is in unbuffered mode with threshold code 00.
- R2: A control write latches ctrl_data bit 0 as the mode (1 = buffered, 16 entries) and bits 7:6 as the threshold code. In buffered mode, characters are read out on rd_data in the order they were pushed, and each pop advances to the next character.
- R3: rx_ready is 1 from the cycle after a character is stored while at least one character is held. It drops to 0 in the cycle after the last held character is popped.
- R4: In buffered mode, a push while 16 characters are held (and no pop is accepted in the same cycle) discards the incoming character, leaves the stored characters unchanged and sets overrun.
- R5: In unbuffered mode, a push while one character is held (with no pop in the same cycle) replaces it on rd_data and sets overrun.
- R6: overrun stays set until a cycle with lsr_read high; it then clears unless a new loss occurs in that same cycle.
- R7: In buffered mode, trig_hit is 1 exactly when occupancy is at least the level given by the threshold code: 00 = 1, 01 = 4, 10 = 8, 11 = 14. In unbuffered mode, trig_hit equals rx_ready.
- R8: err_parity, err_framing and err_break show the flags pushed with the character at the head of the buffer, and are 0 whenever rx_ready is 0.
- R9: lsr_read clears the error flags of the current head character only; flags of characters behind it appear unchanged once they reach the head.
- R10: A control write with ctrl_data bit 1 set empties the buffer (rx_ready is 0 the next cycle). Bit 2 (the transmit-side flush) has no effect on held characters.
- R11: A control write that changes the mode bit empties the buffer.
- R12: A pop while the buffer is empty has no effect; the buffer stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Receiver delivers one character this cycle |
| push_data | input | DW | Received character |
| push_perr | input | 1 | Parity error for this character |
| push_ferr | input | 1 | Framing error for this character |
| push_brk | input | 1 | Break condition for this character |
| pop | input | 1 | Host read of the receive data register |
| lsr_read | input | 1 | Host read of the line status register |
| ctrl_wr | input | 1 | Host write of the buffer control register |
| ctrl_data | input | 8 | Control value: bit 0 mode, bit 1 receive flush, bit 2 transmit flush, bits 7:6 threshold code |
| rd_data | output | DW | Character at the head of the buffer |
| rx_ready | output | 1 | At least one character is held |
| overrun | output | 1 | A character has been lost since the last status read |
| err_parity | output | 1 | Head character has a parity error |
| err_framing | output | 1 | Head character has a framing error |
| err_break | output | 1 | Head character carries a break |
| trig_hit | output | 1 | Occupancy has reached the selected threshold |

## Verification
The properties assume that the host strobes are single-cycle pulses and that every input is a known value outside reset. They also assume that a control write is not needed at the same instant as a push whose arrival must be observed, because a mode change or flush in that cycle wins over the push. The bench drives each strobe for exactly one clock, from the falling edge. It never overlaps a control write with a push, so every property premise is reached through legal sequences only. Full-buffer and overwrite cases are reached by deliberately pushing past capacity rather than by any illegal input.

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          push_perr,
  input  logic          push_ferr,
  input  logic          push_brk,
  input  logic          pop,
  input  logic          lsr_read,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_data,
  output logic [DW-1:0] rd_data,
  output logic          rx_ready,
  output logic          overrun,
  output logic          err_parity,
  output logic          err_framing,
  output logic          err_break,
  output logic          trig_hit
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int EW = DW + 3;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, cap, thr;
  logic [1:0]    trig_sel;
  logic          fifo_en, ovr_q;
  logic [EW-1:0] head;

  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

  wire empty   = (count == '0);
  wire full    = (count == cap);
  wire flush   = ctrl_wr && (ctrl_data[1] || (ctrl_data[0] != fifo_en));
  wire pv      = push_valid && !flush;
  wire do_pop  = pop && !empty && !flush;
  wire accept  = pv && (!full || do_pop);
  wire clobber = pv && full && !do_pop && !fifo_en;
  wire lost    = pv && full && !do_pop && fifo_en;

  always_comb begin
    case (trig_sel)
      2'b00:   thr = CW'(1);
      2'b01:   thr = CW'(4);
      2'b10:   thr = CW'(8);
      default: thr = CW'(14);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      trig_sel <= 2'b00;
    end else if (ctrl_wr) begin
      fifo_en  <= ctrl_data[0];
      trig_sel <= ctrl_data[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(accept) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ovr_q <= 1'b0;
    else if (clobber || lost) ovr_q <= 1'b1;
    else if (lsr_read)       ovr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (lsr_read && !empty) mem[rd_ptr][2:0] <= 3'b000;
    if (accept)       mem[wr_ptr] <= {push_data, push_brk, push_ferr, push_perr};
    else if (clobber) mem[rd_ptr] <= {push_data, push_brk, push_ferr, push_perr};
  end

  assign head        = mem[rd_ptr];
  assign rd_data     = head[EW-1:3];
  assign rx_ready    = !empty;
  assign overrun     = ovr_q;
  assign err_parity  = !empty && head[0];
  assign err_framing = !empty && head[1];
  assign err_break   = !empty && head[2];
  assign trig_hit    = fifo_en ? (count >= thr) : !empty;
endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       push_valid,
  input logic       pop,
  input logic       lsr_read,
  input logic       ctrl_wr,
  input logic [7:0] ctrl_data,
  input logic       rx_ready,
  input logic       overrun,
  input logic       err_parity,
  input logic       err_framing,
  input logic       err_break,
  input logic       trig_hit
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_data[1] |=> !rx_ready); // R10
  AST_OVR_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(push_valid)); // R4
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_read && !push_valid |=> !overrun); // R6
  AST_NO_FLAGS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> !(err_parity || err_framing || err_break)); // R8
  AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> rx_ready); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready && !push_valid && !ctrl_wr |=> !rx_ready); // R12
  AST_PUSH_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !ctrl_wr |=> rx_ready); // R3
endmodule

bind rx_fifo_trig rx_fifo_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop(pop),
  .lsr_read(lsr_read), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
  .rx_ready(rx_ready), .overrun(overrun), .err_parity(err_parity),
  .err_framing(err_framing), .err_break(err_break), .trig_hit(trig_hit)
);

// File: tb/rx_fifo_trig_bench.sv
module rx_fifo_trig_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0, push_perr = 1'b0, push_ferr = 1'b0, push_brk = 1'b0;
  logic [7:0] push_data = '0;
  logic       pop = 1'b0, lsr_read = 1'b0, ctrl_wr = 1'b0;
  logic [7:0] ctrl_data = '0;
  logic [7:0] rd_data;
  logic       rx_ready, overrun, err_parity, err_framing, err_break, trig_hit;
  int         n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_trig u_rx_fifo_trig (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
    .pop(pop), .lsr_read(lsr_read), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .rd_data(rd_data), .rx_ready(rx_ready), .overrun(overrun),
    .err_parity(err_parity), .err_framing(err_framing), .err_break(err_break),
    .trig_hit(trig_hit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    push_valid = 1'b1; push_data = d; push_perr = p; push_ferr = f; push_brk = b;
    @(negedge clk);
    push_valid = 1'b0; push_perr = 1'b0; push_ferr = 1'b0; push_brk = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic do_lsr();
    @(negedge clk); lsr_read = 1'b1;
    @(negedge clk); lsr_read = 1'b0;
  endtask

  task automatic wctl(input logic [7:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_data = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 trig_hit", trig_hit, 0);
    chk("R1 flags", {err_parity, err_framing, err_break}, 0);
  endtask

  task automatic t_unbuffered();
    push(8'h11, 0, 0, 0);
    chk("R3 ready after push", rx_ready, 1);
    chk("R5 hold data", rd_data, 8'h11);
    chk("R7 trig follows ready", trig_hit, 1);
    push(8'h22, 0, 0, 0);
    chk("R5 overwrite data", rd_data, 8'h22);
    chk("R5 overrun set", overrun, 1);
    do_pop();
    chk("R6 overrun sticky", overrun, 1);
    do_lsr();
    chk("R6 overrun cleared", overrun, 0);
    chk("R3 ready after last pop", rx_ready, 0);
    do_pop();
    chk("R12 pop empty", rx_ready, 0);
    push(8'h33, 0, 0, 0);
    chk("R12 next push after empty pop", rd_data, 8'h33);
  endtask

  task automatic t_mode_change();
    wctl(8'h01);
    chk("R11 enable empties", rx_ready, 0);
    push(8'h44, 0, 0, 0);
    wctl(8'h00);
    chk("R11 disable empties", rx_ready, 0);
    wctl(8'h01);
  endtask

  task automatic t_order_full();
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 0, 0, 0);
    chk("R4 no overrun at 16", overrun, 0);
    push(8'hEE, 0, 0, 0);
    chk("R4 overrun on full", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R2 order", rd_data, 8'h40 + i);
      chk("R3 ready while held", rx_ready, 1);
      do_pop();
    end
    chk("R4 dropped char absent", rx_ready, 0);
    do_lsr();
    chk("R6 cleared after full", overrun, 0);
  endtask

  task automatic t_trigger();
    int lv[4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      wctl({2'(s), 6'b000011});
      for (int k = 0; k < lv[s] - 1; k++) push(8'(k), 0, 0, 0);
      chk($sformatf("R7 below level %0d", lv[s]), trig_hit, 0);
      push(8'hA0, 0, 0, 0);
      chk($sformatf("R7 at level %0d", lv[s]), trig_hit, 1);
    end
    wctl(8'h03);
    chk("R10 flush", rx_ready, 0);
  endtask

  task automatic t_flags();
    push(8'h5A, 1, 0, 0);
    push(8'h5B, 0, 1, 0);
    push(8'h5C, 0, 0, 1);
    chk("R8 head parity", {err_parity, err_framing, err_break}, 3'b100);
    do_lsr();
    chk("R9 head cleared", {err_parity, err_framing, err_break}, 3'b000);
    chk("R9 data kept", rd_data, 8'h5A);
    do_pop();
    chk("R9 second framing", {err_parity, err_framing, err_break}, 3'b010);
    do_pop();
    chk("R8 third break", {err_parity, err_framing, err_break}, 3'b001);
    do_pop();
    chk("R8 empty no flags", {err_parity, err_framing, err_break}, 3'b000);
  endtask

  task automatic t_flush_bits();
    push(8'h61, 0, 0, 0);
    push(8'h62, 0, 0, 0);
    wctl(8'h05);
    chk("R10 tx flush no effect ready", rx_ready, 1);
    chk("R10 tx flush no effect data", rd_data, 8'h61);
    wctl(8'h03);
    chk("R10 rx flush", rx_ready, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unbuffered();
    t_mode_change();
    t_order_full();
    t_trigger();
    t_flags();
    t_flush_bits();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule